// File: doc/BRIEF.md
# Block-Transfer Host Register Port

This block is the host-side register window of a block-transfer management-controller interface. The host reaches it through a byte-wide access port with a 2-bit offset that selects one of three registers: a control/status register, a data port and an interrupt mask register. Writes to the data port fill an inbound message buffer, and reads from it drain an outbound message buffer. Both buffers belong to this block, and so do their length and position counters.

A message engine on the controller side reads the inbound bytes through a private index port. When the host raises its request attention, the engine receives a single-cycle request strobe. The engine loads outbound bytes and then announces a response by committing a length. It can also raise or drop a separate system-software attention. The block turns all of these events into one registered, active-high, level interrupt toward the host. That interrupt is gated by a mask enable, a pending flag and a global permission input. A cold reset pulse removes any interrupt setup.

Top module: `bt_host_port`

## Requirements
- R1: Offset 0 selects control, offset 1 selects data and offset 2 selects mask. A read at offset 3 returns 0xFF. After reset the control and mask registers read 0x00 and the interrupt is low.
- R2: The control register reads back with BMC busy at bit 7, host busy at bit 6, system-software attention at bit 4 and response attention at bit 3. All other bits read 0. Writing a 1 to bit 3 or bit 4 of control clears the matching attention flag.
- R3: Writing a 1 to control bit 6 inverts host busy. Each such write flips it again.
- R4: Writing a 1 to control bit 2 sets BMC busy (read bit 7). In the cycle after that write, `req_ready` is high for exactly one cycle.
- R5: Writing a 1 to control bit 0 zeroes the inbound length. Writing a 1 to control bit 1 returns the outbound read position to the first byte.
- R6: Each data-port write increments `in_len`. The byte is stored at index `in_len` only while `in_len` is below the buffer depth. Writes past the end keep counting and leave the stored bytes unchanged.
- R7: A data-port read returns the next outbound byte and advances while bytes remain. After the last byte both position and length return to zero. With nothing pending the read returns 0xFF.
- R8: The mask register reads back with the enable at bit 0 and the pending flag at bit 1. Turning the enable on while either attention flag is set makes the interrupt pending. Turning it off clears any pending interrupt.
- R9: Writing a 1 to mask bit 1 while an interrupt is pending clears it.
- R10: `rsp_ready` clears BMC busy and sets response attention. It raises the interrupt only when `irq_allow` is high, the enable is set and nothing is pending.
- R11: A rising system-software attention raises the interrupt only when `irq_allow` is high, the enable is set and response attention is clear. Dropping it clears a pending interrupt only when response attention is clear.
- R12: A `cold_rst` pulse clears both the enable and the pending flag and drops the interrupt.
- R13: `host_irq` is a registered copy of the pending flag that mask bit 1 reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_sel | input | 1 | Host access strobe, one byte per cycle |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 2 | Register offset |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte for the current offset |
| req_ready | output | 1 | One-cycle request strobe to the engine |
| in_len | output | LEN_W | Inbound write count |
| in_rd_idx | input | log2(BUF_DEPTH) | Engine index into the inbound buffer |
| in_rd_data | output | 8 | Inbound byte at `in_rd_idx` |
| out_ld_en | input | 1 | Engine outbound byte write enable |
| out_ld_idx | input | log2(BUF_DEPTH) | Outbound write index |
| out_ld_data | input | 8 | Outbound write byte |
| rsp_ready | input | 1 | Response commit pulse |
| rsp_len | input | log2(BUF_DEPTH+1) | Committed response length |
| sms_set | input | 1 | Raise system-software attention |
| sms_clr | input | 1 | Drop system-software attention |
| irq_allow | input | 1 | Global interrupt permission |
| cold_rst | input | 1 | Cold reset pulse for the interrupt setup |
| host_irq | output | 1 | Level interrupt to the host |

## Verification
On every cycle the assertions check the following: the request strobe appears only after a request write, host busy flips on each toggle write, and a commit always leaves response attention set with BMC busy clear. They also check that pending is never set without the enable, that disabling or cold reset empties the interrupt state, that each data write advances the inbound count, and that draining the final outbound byte zeroes the pointers. Only the bench scenarios can show the byte contents and their ordering, the overrun case that keeps the early bytes, and rewinding with the read-pointer clear. The same holds for the interplay of the two attention flags with the enable, since the gating outcome depends on the order of earlier events.

// File: rtl/bt_port_pkg.sv
package bt_port_pkg;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_DATA = 2'd1;
  localparam logic [1:0] ADR_MASK = 2'd2;

  localparam int CB_CLR_WR = 0;
  localparam int CB_CLR_RD = 1;
  localparam int CB_H2B    = 2;
  localparam int CB_B2H    = 3;
  localparam int CB_SMS    = 4;
  localparam int CB_HBUSY  = 6;
  localparam int CB_BBUSY  = 7;

  localparam int MB_EN   = 0;
  localparam int MB_PEND = 1;

  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  typedef struct packed {
    logic bbusy;
    logic hbusy;
    logic sms;
    logic b2h;
  } ctrl_state_t;

  function automatic logic [7:0] pack_ctrl(input ctrl_state_t c);
    logic [7:0] v;
    v = 8'h00;
    v[CB_BBUSY] = c.bbusy;
    v[CB_HBUSY] = c.hbusy;
    v[CB_SMS]   = c.sms;
    v[CB_B2H]   = c.b2h;
    return v;
  endfunction

endpackage

// File: rtl/bt_inbox.sv
module bt_inbox #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             clr,
  output logic [CNT_W-1:0] len,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             store;

  assign store = wr_en && (cnt_q < DEPTH_C);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en) cnt_d = cnt_q + 1'b1;
    if (clr)   cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (store) mem[cnt_q[IDX_W-1:0]] <= wr_data;
  end

  assign len     = cnt_q;
  assign rd_data = mem[rd_idx];

  // R6: every data write advances the inbound count, overrun included
  p_len_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R5: write-pointer clear empties the count
  p_len_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/bt_outbox.sv
module bt_outbox #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [7:0]       ld_data,
  input  logic             commit,
  input  logic [PTR_W-1:0] commit_len,
  input  logic             pop,
  input  logic             clr_pos,
  output logic             avail,
  output logic [7:0]       head
);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] pos_q, pos_d, len_q, len_d, pos_inc;

  assign avail   = (pos_q < len_q);
  assign pos_inc = pos_q + 1'b1;
  assign head    = mem[pos_q[IDX_W-1:0]];

  always_comb begin
    pos_d = pos_q;
    len_d = len_q;
    if (clr_pos) pos_d = '0;
    if (pop && avail) begin
      if (pos_inc == len_q) begin
        pos_d = '0;
        len_d = '0;
      end else begin
        pos_d = pos_inc;
      end
    end
    if (commit) begin
      pos_d = '0;
      len_d = commit_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      len_q <= '0;
    end else begin
      pos_q <= pos_d;
      len_q <= len_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_idx] <= ld_data;
  end

  // R7: popping the final byte returns both pointers to zero
  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && avail && (pos_inc == len_q) && !commit) |=> (len_q == '0 && pos_q == '0));

  // R7: a non-empty buffer always has its position inside the message
  p_pos_inside_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != '0) |-> (pos_q < len_q));

  // R10: the engine never commits more bytes than the buffer holds
  p_commit_fits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (commit_len <= PTR_W'(DEPTH)));

endmodule

// File: rtl/bt_irq_ctrl.sv
module bt_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       allow,
  input  logic       rsp_evt,
  input  logic       sms_rise,
  input  logic       sms_fall,
  input  logic       b2h_now,
  input  logic       sms_now,
  input  logic       mask_wr,
  input  logic [1:0] mask_wd,
  input  logic       cold,
  output logic       en,
  output logic       pend
);
  import bt_port_pkg::*;

  logic en_q, en_d, pend_q, pend_d;

  always_comb begin
    en_d   = en_q;
    pend_d = pend_q;
    if (rsp_evt && allow && en_d && !pend_d) pend_d = 1'b1;
    if (sms_rise && allow && en_d && !b2h_now) pend_d = 1'b1;
    if (sms_fall && !b2h_now && pend_d) pend_d = 1'b0;
    if (mask_wr) begin
      if (mask_wd[MB_EN] != en_d) begin
        if (mask_wd[MB_EN]) begin
          if (b2h_now || sms_now) pend_d = 1'b1;
          en_d = 1'b1;
        end else begin
          pend_d = 1'b0;
          en_d   = 1'b0;
        end
      end
      if (mask_wd[MB_PEND] && pend_d) pend_d = 1'b0;
    end
    if (cold) begin
      pend_d = 1'b0;
      en_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  assign en   = en_q;
  assign pend = pend_q;

  // R8: disabling leaves nothing pending
  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !mask_wd[MB_EN]) |=> (!en_q && !pend_q));

  // R8: an interrupt is never pending without the enable
  p_pend_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> en_q);

  // R12: cold reset empties the interrupt setup
  p_cold_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cold |=> (!en_q && !pend_q));

  // R10: without global permission only a mask write can raise pending
  p_allow_gates_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!allow && !mask_wr) |=> !$rose(pend_q));

endmodule

// File: rtl/bt_host_port.sv
module bt_host_port #(
  parameter int BUF_DEPTH = 64,
  parameter int LEN_W     = 16,
  localparam int IDX_W = $clog2(BUF_DEPTH),
  localparam int PTR_W = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hst_sel,
  input  logic             hst_we,
  input  logic [1:0]       hst_addr,
  input  logic [7:0]       hst_wdata,
  output logic [7:0]       hst_rdata,
  output logic             req_ready,
  output logic [LEN_W-1:0] in_len,
  input  logic [IDX_W-1:0] in_rd_idx,
  output logic [7:0]       in_rd_data,
  input  logic             out_ld_en,
  input  logic [IDX_W-1:0] out_ld_idx,
  input  logic [7:0]       out_ld_data,
  input  logic             rsp_ready,
  input  logic [PTR_W-1:0] rsp_len,
  input  logic             sms_set,
  input  logic             sms_clr,
  input  logic             irq_allow,
  input  logic             cold_rst,
  output logic             host_irq
);
  import bt_port_pkg::*;

  logic        ctrl_wr, data_wr, mask_wr, data_rd;
  logic        sms_rise, sms_fall;
  logic        req_q, req_d;
  ctrl_state_t ctl_q, ctl_d;
  logic        out_avail;
  logic [7:0]  out_head;
  logic        irq_en, irq_pend;

  assign ctrl_wr = hst_sel && hst_we  && (hst_addr == ADR_CTRL);
  assign data_wr = hst_sel && hst_we  && (hst_addr == ADR_DATA);
  assign mask_wr = hst_sel && hst_we  && (hst_addr == ADR_MASK);
  assign data_rd = hst_sel && !hst_we && (hst_addr == ADR_DATA);

  assign sms_rise = sms_set && !ctl_q.sms;
  assign sms_fall = sms_clr && !sms_set && ctl_q.sms;

  always_comb begin
    ctl_d = ctl_q;
    if (ctrl_wr) begin
      if (hst_wdata[CB_B2H])   ctl_d.b2h   = 1'b0;
      if (hst_wdata[CB_SMS])   ctl_d.sms   = 1'b0;
      if (hst_wdata[CB_HBUSY]) ctl_d.hbusy = ~ctl_q.hbusy;
      if (hst_wdata[CB_H2B])   ctl_d.bbusy = 1'b1;
    end
    if (rsp_ready) begin
      ctl_d.bbusy = 1'b0;
      ctl_d.b2h   = 1'b1;
    end
    if (sms_rise)      ctl_d.sms = 1'b1;
    else if (sms_fall) ctl_d.sms = 1'b0;
    req_d = ctrl_wr && hst_wdata[CB_H2B];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      req_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      req_q <= req_d;
    end
  end

  assign req_ready = req_q;

  bt_inbox #(.DEPTH(BUF_DEPTH), .CNT_W(LEN_W)) u_inbox (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (data_wr),
    .wr_data (hst_wdata),
    .clr     (ctrl_wr && hst_wdata[CB_CLR_WR]),
    .len     (in_len),
    .rd_idx  (in_rd_idx),
    .rd_data (in_rd_data)
  );

  bt_outbox #(.DEPTH(BUF_DEPTH)) u_outbox (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_en      (out_ld_en),
    .ld_idx     (out_ld_idx),
    .ld_data    (out_ld_data),
    .commit     (rsp_ready),
    .commit_len (rsp_len),
    .pop        (data_rd),
    .clr_pos    (ctrl_wr && hst_wdata[CB_CLR_RD]),
    .avail      (out_avail),
    .head       (out_head)
  );

  bt_irq_ctrl u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .allow    (irq_allow),
    .rsp_evt  (rsp_ready),
    .sms_rise (sms_rise),
    .sms_fall (sms_fall),
    .b2h_now  (ctl_q.b2h),
    .sms_now  (ctl_q.sms),
    .mask_wr  (mask_wr),
    .mask_wd  (hst_wdata[1:0]),
    .cold     (cold_rst),
    .en       (irq_en),
    .pend     (irq_pend)
  );

  assign host_irq = irq_pend;

  always_comb begin
    hst_rdata = IDLE_BYTE;
    case (hst_addr)
      ADR_CTRL: hst_rdata = pack_ctrl(ctl_q);
      ADR_DATA: hst_rdata = out_avail ? out_head : IDLE_BYTE;
      ADR_MASK: begin
        hst_rdata          = 8'h00;
        hst_rdata[MB_EN]   = irq_en;
        hst_rdata[MB_PEND] = irq_pend;
      end
      default:  hst_rdata = IDLE_BYTE;
    endcase
  end

  // R4: the request strobe only follows a request write
  p_req_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> $past(hst_sel && hst_we && hst_addr == ADR_CTRL && hst_wdata[CB_H2B]));

  // R4: a request write leaves BMC busy set unless a response lands at once
  p_bbusy_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && hst_wdata[CB_H2B] && !rsp_ready) |=> ctl_q.bbusy);

  // R3: each toggle write flips host busy
  p_hbusy_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && hst_wdata[CB_HBUSY]) |=> (ctl_q.hbusy != $past(ctl_q.hbusy)));

  // R10: a response commit frees BMC busy and flags attention
  p_rsp_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> (ctl_q.b2h && !ctl_q.bbusy));

  // R1: the unused offset reads as all ones
  p_bad_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_addr == 2'd3) |-> (hst_rdata == 8'hFF));

endmodule

// File: tb/bt_host_port_test.sv
module bt_host_port_test;

  localparam int DEPTH = 64;
  localparam int LW    = 16;
  localparam int IW    = $clog2(DEPTH);
  localparam int PW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hst_sel = 1'b0, hst_we = 1'b0;
  logic [1:0]    hst_addr = 2'd0;
  logic [7:0]    hst_wdata = 8'h00;
  logic [7:0]    hst_rdata;
  logic          req_ready;
  logic [LW-1:0] in_len;
  logic [IW-1:0] in_rd_idx = '0;
  logic [7:0]    in_rd_data;
  logic          out_ld_en = 1'b0;
  logic [IW-1:0] out_ld_idx = '0;
  logic [7:0]    out_ld_data = 8'h00;
  logic          rsp_ready = 1'b0;
  logic [PW-1:0] rsp_len = '0;
  logic          sms_set = 1'b0, sms_clr = 1'b0;
  logic          irq_allow = 1'b1;
  logic          cold_rst = 1'b0;
  logic          host_irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic seen_req;

  always #10 clk = ~clk;

  bt_host_port #(.BUF_DEPTH(DEPTH), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_we(hst_we),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .req_ready(req_ready), .in_len(in_len), .in_rd_idx(in_rd_idx),
    .in_rd_data(in_rd_data), .out_ld_en(out_ld_en), .out_ld_idx(out_ld_idx),
    .out_ld_data(out_ld_data), .rsp_ready(rsp_ready), .rsp_len(rsp_len),
    .sms_set(sms_set), .sms_clr(sms_clr), .irq_allow(irq_allow),
    .cold_rst(cold_rst), .host_irq(host_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hst_sel = 1'b1; hst_we = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_sel = 1'b0; hst_we = 1'b0;
    #1 seen_req = req_ready;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    hst_sel = 1'b1; hst_we = 1'b0; hst_addr = a;
    #2 d = hst_rdata;
    @(negedge clk);
    hst_sel = 1'b0;
    #1;
  endtask

  task automatic load_out(input int idx, input logic [7:0] d);
    @(negedge clk);
    out_ld_en = 1'b1; out_ld_idx = IW'(idx); out_ld_data = d;
    @(negedge clk);
    out_ld_en = 1'b0;
  endtask

  task automatic commit(input int n);
    @(negedge clk);
    rsp_ready = 1'b1; rsp_len = PW'(n);
    @(negedge clk);
    rsp_ready = 1'b0;
    #1;
  endtask

  task automatic pulse_sms(input bit up);
    @(negedge clk);
    if (up) sms_set = 1'b1; else sms_clr = 1'b1;
    @(negedge clk);
    sms_set = 1'b0; sms_clr = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); chk("R1 ctrl after reset", v, 8'h00);
    rd(2'd2, v); chk("R1 mask after reset", v, 8'h00);
    chk("R13 irq after reset", host_irq, 1'b0);
    rd(2'd3, v); chk("R1 offset 3 read", v, 8'hFF);
    rd(2'd1, v); chk("R7 empty data read", v, 8'hFF);
  endtask

  task automatic t_inbound;
    wr(2'd1, 8'hAA); wr(2'd1, 8'hBB); wr(2'd1, 8'hCC);
    chk("R6 in_len after 3", in_len, 16'd3);
    in_rd_idx = 0; #1 chk("R6 byte0", in_rd_data, 8'hAA);
    in_rd_idx = 1; #1 chk("R6 byte1", in_rd_data, 8'hBB);
    in_rd_idx = 2; #1 chk("R6 byte2", in_rd_data, 8'hCC);
    wr(2'd0, 8'h01);
    chk("R5 write pointer clear", in_len, 16'd0);
  endtask

  task automatic t_overrun;
    for (int i = 0; i < DEPTH + 2; i++) wr(2'd1, 8'(i + 8'h10));
    chk("R6 overrun count", in_len, 16'(DEPTH + 2));
    in_rd_idx = IW'(DEPTH - 1); #1 chk("R6 last slot", in_rd_data, 8'(DEPTH - 1 + 8'h10));
    in_rd_idx = 0; #1 chk("R6 first slot kept", in_rd_data, 8'h10);
    wr(2'd0, 8'h01);
    chk("R5 clear after overrun", in_len, 16'd0);
  endtask

  task automatic t_busy;
    logic [7:0] v;
    wr(2'd0, 8'h04);
    chk("R4 request strobe", seen_req, 1'b1);
    @(negedge clk); #1 chk("R4 strobe one cycle", req_ready, 1'b0);
    rd(2'd0, v); chk("R4 bmc busy set", v, 8'h80);
    wr(2'd0, 8'h40); rd(2'd0, v); chk("R3 host busy on", v, 8'hC0);
    wr(2'd0, 8'h40); rd(2'd0, v); chk("R3 host busy off", v, 8'h80);
  endtask

  task automatic t_response;
    logic [7:0] v;
    load_out(0, 8'h11); load_out(1, 8'h22); load_out(2, 8'h33);
    commit(3);
    rd(2'd0, v); chk("R10 busy clear attn set", v, 8'h08);
    chk("R10 no irq while disabled", host_irq, 1'b0);
    rd(2'd1, v); chk("R7 out byte0", v, 8'h11);
    rd(2'd1, v); chk("R7 out byte1", v, 8'h22);
    rd(2'd1, v); chk("R7 out byte2", v, 8'h33);
    rd(2'd1, v); chk("R7 drained read", v, 8'hFF);
    wr(2'd0, 8'h08); rd(2'd0, v); chk("R2 response attn cleared", v, 8'h00);
  endtask

  task automatic t_rewind;
    logic [7:0] v;
    for (int i = 0; i < 4; i++) load_out(i, 8'(8'h40 + i));
    commit(4);
    rd(2'd1, v); chk("R7 rewind byte0", v, 8'h40);
    rd(2'd1, v); chk("R7 rewind byte1", v, 8'h41);
    wr(2'd0, 8'h02);
    rd(2'd1, v); chk("R5 read pointer clear", v, 8'h40);
    wr(2'd0, 8'h08);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    commit(1);
    chk("R10 no irq before enable", host_irq, 1'b0);
    wr(2'd2, 8'h01);
    chk("R8 enable with attention", host_irq, 1'b1);
    rd(2'd2, v); chk("R8 mask pending", v, 8'h03);
    wr(2'd2, 8'h03);
    chk("R9 pending cleared", host_irq, 1'b0);
    rd(2'd2, v); chk("R9 mask after clear", v, 8'h01);
    commit(1);
    chk("R10 raise when enabled", host_irq, 1'b1);
    rd(2'd2, v); chk("R13 irq mirrors pending", v[1], host_irq);
    wr(2'd2, 8'h00);
    chk("R8 disable drops irq", host_irq, 1'b0);
    rd(2'd2, v); chk("R8 mask after disable", v, 8'h00);
    wr(2'd0, 8'h08);
    wr(2'd2, 8'h01);
    chk("R8 enable without attention", host_irq, 1'b0);
  endtask

  task automatic t_allow;
    logic [7:0] v;
    irq_allow = 1'b0;
    commit(1);
    chk("R10 blocked by allow", host_irq, 1'b0);
    rd(2'd0, v); chk("R10 attn set anyway", v, 8'h08);
    wr(2'd0, 8'h08);
    irq_allow = 1'b1;
  endtask

  task automatic t_sms;
    logic [7:0] v;
    pulse_sms(1'b1);
    chk("R11 sms raises irq", host_irq, 1'b1);
    rd(2'd0, v); chk("R11 sms flag", v, 8'h10);
    pulse_sms(1'b0);
    chk("R11 sms drop lowers irq", host_irq, 1'b0);
    commit(1);
    wr(2'd2, 8'h03);
    chk("R9 clear before sms", host_irq, 1'b0);
    pulse_sms(1'b1);
    chk("R11 sms blocked by attn", host_irq, 1'b0);
    rd(2'd0, v); chk("R11 both flags", v, 8'h18);
    wr(2'd2, 8'h00); wr(2'd2, 8'h01);
    chk("R8 re-enable with attention", host_irq, 1'b1);
    pulse_sms(1'b0);
    chk("R11 drop kept by attn", host_irq, 1'b1);
    wr(2'd0, 8'h10);
    rd(2'd0, v); chk("R2 sms write clear", v, 8'h08);
  endtask

  task automatic t_cold;
    logic [7:0] v;
    @(negedge clk); cold_rst = 1'b1;
    @(negedge clk); cold_rst = 1'b0;
    #1 chk("R12 cold drops irq", host_irq, 1'b0);
    rd(2'd2, v); chk("R12 mask after cold", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_inbound;
    t_overrun;
    t_busy;
    t_response;
    t_rewind;
    t_mask;
    t_allow;
    t_sms;
    t_cold;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule